// File: doc/BRIEF.md
# UART Receive Character Timeout Detector

This block watches the receive side of a serial port and flags a stalled stream. Characters may sit in the receive FIFO below the level that would raise a data-available interrupt. When that happens and the line stays idle, nothing else wakes software. The detector counts baud bit-clock ticks from the last moment of activity. Activity is a character landing in the FIFO or the CPU popping one. When the count passes a programmable 7-bit limit while the FIFO still holds data, the detector raises a timeout request.

The request goes to the port's interrupt prioritizer, which ranks it alongside data-available. Software answers by reading the FIFO, and that read clears the request and restarts the count. The baud generator and the FIFO itself sit outside this block. This block only sees their tick, strobes and non-empty flag.

Top module: `rx_stall_timer`

## Requirements
- R1: The detector is armed only while both `rx_int_en` and `stall_en` are 1. While either is 0 the request is 0 one clock later, and no idle time accumulates.
- R2: While `fifo_has_data` is 0 the idle count is held at zero and the request cannot rise.
- R3: Each cycle with `bit_tick`=1 and no restart condition adds one to the idle count. The request rises after the clock edge of the tick that makes the idle count exceed `stall_limit`. That is the (`stall_limit`+1)-th qualifying tick, so a limit of 127 fires on the 128th tick.
- R4: A cycle with `char_rcvd`=1 restarts the idle count from zero but leaves an already raised request set.
- R5: A cycle with `fifo_pop`=1 restarts the idle count and drives the request to 0 after that clock edge.
- R6: With `stall_limit`=0 the request rises on the first qualifying tick after the last activity.
- R7: When `char_rcvd` and `fifo_pop` are both 1 in one cycle, the count restarts and the request is cleared.
- R8: Once raised, the request stays at 1 across any number of further ticks until a pop or disarm; the count does not wrap and re-arm.
- R9: A `bit_tick` in the same cycle as a restart condition (strobe, empty FIFO or disarm) is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | One-cycle pulse per baud bit period |
| char_rcvd | input | 1 | One-cycle pulse when a character enters the receive FIFO |
| fifo_pop | input | 1 | One-cycle pulse when the CPU reads one character from the FIFO |
| fifo_has_data | input | 1 | Receive FIFO holds at least one character |
| rx_int_en | input | 1 | General receive interrupt enable |
| stall_en | input | 1 | Dedicated timeout enable |
| stall_limit | input | 7 | Idle limit in bit-clock ticks |
| stall_irq | output | 1 | Timeout interrupt request |

## Verification
The bench builds the block with its default 7-bit limit width. Limits of 0, 3 and 127 are all reachable, so the first-tick case, a short ordinary window and the full-range window with its 128-tick boundary are each exercised. Ticks are spaced irregularly, and strobes are placed on tick cycles to show that restarts win. The enables and the FIFO flag are toggled while a request is pending, so the clear paths are observed directly at the request output.

// File: rtl/rx_stall_pkg.sv
package rx_stall_pkg;
  localparam int unsigned STALL_LIMIT_W = 7;

  typedef struct packed {
    logic armed;
    logic restart;
    logic count_ok;
  } stall_ctl_t;
endpackage

// File: rtl/rx_stall_arm.sv
module rx_stall_arm
  import rx_stall_pkg::*;
(
  input  logic       bit_tick,
  input  logic       char_rcvd,
  input  logic       fifo_pop,
  input  logic       fifo_has_data,
  input  logic       rx_int_en,
  input  logic       stall_en,
  output stall_ctl_t ctl
);
  always_comb begin
    ctl.armed    = rx_int_en & stall_en;
    ctl.restart  = char_rcvd | fifo_pop | ~fifo_has_data | ~ctl.armed;
    ctl.count_ok = bit_tick & ~ctl.restart;
  end
endmodule

// File: rtl/rx_stall_count.sv
module rx_stall_count #(
  parameter int unsigned LIMIT_W = 7,
  localparam int unsigned CNT_W  = LIMIT_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               count_ok,
  input  logic [LIMIT_W-1:0] limit,
  output logic               expire
);
  logic [CNT_W-1:0] idle_q, idle_d;
  logic [CNT_W-1:0] limit_x;
  logic             past_limit;

  always_comb begin
    limit_x    = {1'b0, limit};
    past_limit = (idle_q > limit_x);
    expire     = count_ok & (idle_q >= limit_x);
  end

  always_comb begin
    idle_d = idle_q;
    if (restart) begin
      idle_d = '0;
    end else if (count_ok && !past_limit) begin
      idle_d = idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
    end else begin
      idle_q <= idle_d;
    end
  end
endmodule

// File: rtl/rx_stall_flag.sv
module rx_stall_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic pop,
  input  logic expire,
  output logic req
);
  logic req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (pop || !armed) begin
      req_d = 1'b0;
    end else if (expire) begin
      req_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/rx_stall_timer.sv
module rx_stall_timer
  import rx_stall_pkg::*;
#(
  parameter int unsigned LIMIT_W = STALL_LIMIT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               char_rcvd,
  input  logic               fifo_pop,
  input  logic               fifo_has_data,
  input  logic               rx_int_en,
  input  logic               stall_en,
  input  logic [LIMIT_W-1:0] stall_limit,
  output logic               stall_irq
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  stall_ctl_t ctl;
  logic       expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  rx_stall_arm u_arm (
    .bit_tick      (bit_tick),
    .char_rcvd     (char_rcvd),
    .fifo_pop      (fifo_pop),
    .fifo_has_data (fifo_has_data),
    .rx_int_en     (rx_int_en),
    .stall_en      (stall_en),
    .ctl           (ctl)
  );

  rx_stall_count #(.LIMIT_W(LIMIT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .restart  (ctl.restart),
    .count_ok (ctl.count_ok),
    .limit    (stall_limit),
    .expire   (expire)
  );

  rx_stall_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .armed  (ctl.armed),
    .pop    (fifo_pop),
    .expire (expire),
    .req    (stall_irq)
  );
endmodule

// File: rtl/rx_stall_timer_chk.sv
module rx_stall_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic char_rcvd,
  input logic fifo_pop,
  input logic fifo_has_data,
  input logic rx_int_en,
  input logic stall_en,
  input logic stall_irq
);
  a_r1_disarm_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_int_en && stall_en) |=> !stall_irq);

  a_r5_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !stall_irq);

  a_r2_rise_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_irq) |-> $past(fifo_has_data));

  a_r3_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_irq) |-> $past(bit_tick));

  a_r9_no_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_irq) |-> !$past(char_rcvd) && !$past(fifo_pop));

  a_r8_held_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stall_irq && !fifo_pop && rx_int_en && stall_en |=> stall_irq);
endmodule

bind rx_stall_timer rx_stall_timer_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .bit_tick      (bit_tick),
  .char_rcvd     (char_rcvd),
  .fifo_pop      (fifo_pop),
  .fifo_has_data (fifo_has_data),
  .rx_int_en     (rx_int_en),
  .stall_en      (stall_en),
  .stall_irq     (stall_irq)
);

// File: tb/rx_stall_timer_tb_top.sv
module rx_stall_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bit_tick, char_rcvd, fifo_pop, fifo_has_data, rx_int_en, stall_en;
  logic [LW-1:0] stall_limit;
  logic          stall_irq;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    idle    = 0;
  bit    m_req   = 1'b0;
  string tag     = "R1";
  bit    done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_stall_timer #(.LIMIT_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .char_rcvd(char_rcvd),
    .fifo_pop(fifo_pop), .fifo_has_data(fifo_has_data), .rx_int_en(rx_int_en),
    .stall_en(stall_en), .stall_limit(stall_limit), .stall_irq(stall_irq)
  );

  task automatic check(input bit act, input bit exp, input string t);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: stall_irq=%0b expected %0b at %0t", t, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, update model at posedge, compare at next negedge
  task automatic cyc(input bit tk, input bit ch, input bit pp);
    bit quiet;
    bit armed;
    bit hit;
    bit_tick  = tk;
    char_rcvd = ch;
    fifo_pop  = pp;
    @(posedge clk);
    armed = rx_int_en && stall_en;
    quiet = armed && fifo_has_data && !ch && !pp;
    hit   = 1'b0;
    if (!quiet) idle = 0;
    else if (tk) begin
      idle = idle + 1;
      hit  = (idle > int'(stall_limit));
    end
    if (pp || !armed) m_req = 1'b0;
    else if (hit) m_req = 1'b1;
    @(negedge clk);
    check(stall_irq, m_req, tag);
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 1'b0, 1'b0);
      for (int g = 0; g < gap; g++) cyc(1'b0, 1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bit_tick = 0; char_rcvd = 0; fifo_pop = 0; fifo_has_data = 0;
    rx_int_en = 0; stall_en = 0; stall_limit = '0;
    repeat (3) @(negedge clk);
    check(stall_irq, 1'b0, "R1 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(stall_irq, 1'b0, "R1 after reset");

    // R3: limit 3, ticks spaced by 2 idle cycles -> fires on 4th tick
    tag = "R3";
    rx_int_en = 1; stall_en = 1; fifo_has_data = 1; stall_limit = 7'd3;
    cyc(0, 1, 0);
    ticks(3, 2);
    check(stall_irq, 1'b0, "R3 three ticks not enough");
    ticks(1, 0);
    check(stall_irq, 1'b1, "R3 fourth tick fires");

    // R8: stays high across many ticks
    tag = "R8";
    ticks(300, 0);
    check(stall_irq, 1'b1, "R8 held after many ticks");

    // R4: receive strobe leaves request set, restarts count
    tag = "R4";
    cyc(1, 1, 0);
    check(stall_irq, 1'b1, "R4 char keeps request");
    ticks(2, 1);

    // R5: pop clears
    tag = "R5";
    cyc(0, 0, 1);
    check(stall_irq, 1'b0, "R5 pop clears");
    ticks(3, 0);
    check(stall_irq, 1'b0, "R5 count restarted by pop");
    ticks(1, 3);
    check(stall_irq, 1'b1, "R5 refires after full window");

    // R6: limit zero fires on first tick
    tag = "R6";
    stall_limit = 7'd0;
    cyc(0, 0, 1);
    cyc(0, 0, 0);
    check(stall_irq, 1'b0, "R6 no tick no fire");
    cyc(1, 0, 0);
    check(stall_irq, 1'b1, "R6 first tick fires");

    // R7: both strobes together restart and clear
    tag = "R7";
    cyc(1, 1, 1);
    check(stall_irq, 1'b0, "R7 simultaneous strobes clear");

    // R9: ticks on restart cycles do not count
    tag = "R9";
    stall_limit = 7'd1;
    cyc(1, 1, 0);
    cyc(1, 0, 0);
    check(stall_irq, 1'b0, "R9 tick with char not counted");
    cyc(1, 0, 0);
    check(stall_irq, 1'b1, "R9 second clean tick fires");

    // R2: empty FIFO holds count and blocks request
    tag = "R2";
    cyc(0, 0, 1);
    fifo_has_data = 0;
    ticks(40, 1);
    check(stall_irq, 1'b0, "R2 empty never fires");
    fifo_has_data = 1;
    ticks(1, 0);
    check(stall_irq, 1'b0, "R2 count was held at zero");
    ticks(1, 0);
    check(stall_irq, 1'b1, "R2 fires once data present");

    // R1: disarm drops request; disarmed timer does not count
    tag = "R1";
    stall_en = 0;
    cyc(0, 0, 0);
    check(stall_irq, 1'b0, "R1 stall_en low clears");
    ticks(20, 0);
    check(stall_irq, 1'b0, "R1 disarmed stays low");
    stall_en = 1; rx_int_en = 0;
    ticks(20, 0);
    check(stall_irq, 1'b0, "R1 rx_int_en low stays low");
    rx_int_en = 1;
    ticks(1, 0);
    check(stall_irq, 1'b0, "R1 no carried idle time");

    // R3: full range limit 127 -> 128th tick fires
    tag = "R3";
    stall_limit = 7'd127;
    cyc(0, 0, 1);
    ticks(127, 1);
    check(stall_irq, 1'b0, "R3 127 ticks at limit 127");
    ticks(1, 0);
    check(stall_irq, 1'b1, "R3 128th tick fires");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule